// File: doc/BRIEF.md
# Fly-by DMA Controller (single channel)

This block moves data straight between system memory and one peripheral over a shared bus. The data itself never passes through it. The CPU first programs a start address, an item count and a direction, then sets the enable bit. When the peripheral raises its request line, the controller asks the processor for the bus with HOLD. It waits until the processor grants the bus with HLDA. It then runs one combined bus cycle: it drives the memory address, raises the acknowledge line to the peripheral, and pulses a memory strobe and an I/O strobe together. The peripheral needs no address decode. It responds to the acknowledge line alone.

In the memory-to-peripheral direction, the cycle pairs a memory read with an I/O write. In the other direction, it pairs an I/O read with a memory write. Each request produces exactly one transfer, and the bus goes back to the processor after every transfer. After each transfer the address steps up and the remaining count steps down. When the count reaches zero, the controller sets a done flag and clears its own enable.

Top module: `flyby_dma`

## Requirements
- R1: While reset is asserted, and after it is released, hold, dack and all four strobes are low. Reads of the address, count, control and status registers return 0.
- R2: When enable is set, the count is nonzero and dreq is sampled high in idle, hold goes high one cycle later.
- R3: While hold is high and hlda is sampled low, dack and every strobe stay low and hold stays high.
- R4: One cycle after hlda is sampled high in the hold state, dack goes high and the strobe pair pulses for exactly one cycle. During that cycle mem_addr equals the current address register.
- R5: Control bit 1 selects the direction. A value of 0 pulses mem_rd together with io_wr. A value of 1 pulses io_rd together with mem_wr. The other pair stays low.
- R6: After each transfer the address register increments by one, wrapping at its width, and the count register decrements by one.
- R7: The cycle after the transfer pulse, hold and dack are both low. Each request produces one transfer.
- R8: If dreq falls while hold waits for hlda, hold drops one cycle later. No transfer happens and the count is unchanged.
- R9: When the count reaches zero, status bit 0 (done) becomes 1 and the enable bit is cleared. Later dreq pulses do not raise hold.
- R10: CPU writes made while the controller is busy (status bit 2 = 1, any state other than idle) are ignored.
- R11: When enable (control bit 0) is 0, or the count is 0, dreq is ignored and hold stays low.
- R12: The register offsets are: 0 = address, 1 = count, 2 = control {dir, enable}, 3 = status {busy, enable, done}. Read data appears on cpu_rdata one cycle after cpu_rd is sampled. Writing control clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | REG_W | Register write data |
| cpu_rdata | output | REG_W | Registered read data |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Peripheral acknowledge, qualifies the peripheral for the cycle |
| hold | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| mem_addr | output | ADDR_W | Memory address, valid while dack is high |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |

## Verification
Every output is registered, so:
- hold answers a sampled dreq one edge later.
- The dack and strobe cycle follows one edge after hlda is sampled.
- Release follows one edge after the strobe.
- Register reads land one edge after cpu_rd.

The bench drives inputs and samples outputs on the falling clock edge. It waits exactly that number of rising edges before each comparison. It holds hlda low for an extra cycle so the wait-for-grant window is observed. It reads the address and count back only after the controller has returned to idle.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_XFER = 2'd2,
    ST_REL  = 2'd3
  } dma_state_e;

  localparam logic [1:0] OFS_ADDR  = 2'd0;
  localparam logic [1:0] OFS_COUNT = 2'd1;
  localparam logic [1:0] OFS_CTRL  = 2'd2;
  localparam logic [1:0] OFS_STAT  = 2'd3;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_DIR = 1;
  localparam int STAT_DONE = 0;
  localparam int STAT_EN   = 1;
  localparam int STAT_BUSY = 2;
endpackage

// File: rtl/flyby_dma_regs.sv
module flyby_dma_regs
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              busy,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              go,
  output logic              dir
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q, dir_q, done_q;
  logic [REG_W-1:0]  rd_mux;
  logic              unused_wbits;

  assign unused_wbits = ^cpu_wdata[REG_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      cnt_q     <= '0;
      en_q      <= 1'b0;
      dir_q     <= 1'b0;
      done_q    <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      if (cpu_wr && !busy) begin
        case (cpu_addr)
          OFS_ADDR:  addr_q <= cpu_wdata[ADDR_W-1:0];
          OFS_COUNT: cnt_q  <= cpu_wdata[CNT_W-1:0];
          OFS_CTRL: begin
            en_q   <= cpu_wdata[CTRL_EN];
            dir_q  <= cpu_wdata[CTRL_DIR];
            done_q <= 1'b0;
          end
          default: ;
        endcase
      end
      if (step) begin
        addr_q <= addr_q + ADDR_W'(1);
        cnt_q  <= cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) begin
          done_q <= 1'b1;
          en_q   <= 1'b0;
        end
      end
      if (cpu_rd) cpu_rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (cpu_addr)
      OFS_ADDR:  rd_mux = REG_W'(addr_q);
      OFS_COUNT: rd_mux = REG_W'(cnt_q);
      OFS_CTRL: begin
        rd_mux[CTRL_EN]  = en_q;
        rd_mux[CTRL_DIR] = dir_q;
      end
      default: begin
        rd_mux[STAT_DONE] = done_q;
        rd_mux[STAT_EN]   = en_q;
        rd_mux[STAT_BUSY] = busy;
      end
    endcase
  end

  assign cur_addr = addr_q;
  assign go       = en_q && (cnt_q != '0);
  assign dir      = dir_q;
endmodule

// File: rtl/flyby_dma_fsm.sv
module flyby_dma_fsm
  import flyby_dma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dreq,
  input  logic hlda,
  input  logic go,
  input  logic dir,
  output logic hold,
  output logic dack,
  output logic mem_rd,
  output logic mem_wr,
  output logic io_rd,
  output logic io_wr,
  output logic busy,
  output logic step
);
  dma_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (go && dreq) st_d = ST_HOLD;
      ST_HOLD: begin
        if (!dreq)     st_d = ST_REL;
        else if (hlda) st_d = ST_XFER;
      end
      ST_XFER: st_d = ST_REL;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      hold   <= 1'b0;
      dack   <= 1'b0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      io_rd  <= 1'b0;
      io_wr  <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold   <= (st_d == ST_HOLD) || (st_d == ST_XFER);
      dack   <= (st_d == ST_XFER);
      mem_rd <= (st_d == ST_XFER) && !dir;
      io_wr  <= (st_d == ST_XFER) && !dir;
      io_rd  <= (st_d == ST_XFER) && dir;
      mem_wr <= (st_d == ST_XFER) && dir;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign step = (st_q == ST_XFER);
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              dreq,
  output logic              dack,
  output logic              hold,
  input  logic              hlda,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr
);
  logic busy, step, go, dir;

  flyby_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .busy(busy), .step(step), .cur_addr(mem_addr), .go(go), .dir(dir)
  );

  flyby_dma_fsm u_fsm (
    .clk(clk), .rst(rst), .dreq(dreq), .hlda(hlda), .go(go), .dir(dir),
    .hold(hold), .dack(dack), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .busy(busy), .step(step)
  );
endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              dreq,
  input logic              hlda,
  input logic              hold,
  input logic              dack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              io_rd,
  input logic              io_wr
);
  logic any_strobe;
  assign any_strobe = mem_rd || mem_wr || io_rd || io_wr;

  assert_hold_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(dreq));

  assert_grant_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dack) |-> ($past(hlda) && $past(hold)));

  assert_strobe_granted_R4: assert property (@(posedge clk) disable iff (rst)
    any_strobe |-> (dack && hold));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    any_strobe |=> !any_strobe);

  assert_pairing_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd == io_wr) && (mem_wr == io_rd) && !(mem_rd && mem_wr));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(dack) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    dack |=> (!dack && !hold));

  assert_abandon_R8: assert property (@(posedge clk) disable iff (rst)
    (hold && !dack && !dreq) |=> !hold);
endmodule

bind flyby_dma flyby_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .dreq(dreq), .hlda(hlda), .hold(hold), .dack(dack),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr)
);

// File: tb/flyby_dma_tb.sv
`timescale 1ns/1ps
module flyby_dma_tb;
  localparam int AW = 16;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0]    cpu_addr = '0;
  logic [RW-1:0] cpu_wdata = '0;
  logic [RW-1:0] cpu_rdata;
  logic          dreq = 1'b0, hlda = 1'b0;
  logic          dack, hold, mem_rd, mem_wr, io_rd, io_wr;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flyby_dma #(.ADDR_W(AW), .CNT_W(16), .REG_W(RW)) u_dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dreq(dreq), .dack(dack), .hold(hold), .hlda(hlda),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr)
  );

  // {dir, start address, count}
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 16'h0100, 16'd3},
    {1'b1, 16'h2000, 16'd2},
    {1'b0, 16'hFFFF, 16'd2},
    {1'b1, 16'h0042, 16'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [RW-1:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [RW-1:0] d);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  function automatic logic [31:0] bus_sig();
    return {26'd0, hold, dack, mem_rd, mem_wr, io_rd, io_wr};
  endfunction

  task automatic one_transfer(input logic [AW-1:0] exp_addr, input logic d);
    dreq = 1'b1;
    @(negedge clk);
    chk("R2 hold after dreq", bus_sig(), 32'h20);
    @(negedge clk);
    chk("R3 no dack before hlda", bus_sig(), 32'h20);
    hlda = 1'b1;
    @(negedge clk);
    chk("R5 strobe pair", bus_sig(), d ? 32'h36 : 32'h39);
    chk("R4 address on bus", {16'd0, mem_addr}, {16'd0, exp_addr});
    dreq = 1'b0;
    @(negedge clk);
    chk("R7 release after pulse", bus_sig(), 32'h0);
    hlda = 1'b0;
    @(negedge clk);
  endtask

  task automatic no_hold_window(input string req);
    dreq = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(req, bus_sig(), 32'h0);
    end
    dreq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [RW-1:0] rd;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", bus_sig(), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", bus_sig(), 32'h0);
    for (int r = 0; r < 4; r++) begin
      cpu_read(2'(r), rd);
      chk("R1 register zero", {16'd0, rd}, 32'h0);
    end

    for (int v = 0; v < 4; v++) begin
      logic          vd;
      logic [15:0]   va, vc;
      vd = VEC[v][32];
      va = VEC[v][31:16];
      vc = VEC[v][15:0];
      cpu_write(2'd0, va);
      cpu_write(2'd1, vc);
      cpu_write(2'd2, {14'd0, vd, 1'b1});
      cpu_read(2'd2, rd);
      chk("R12 control readback", {16'd0, rd}, {30'd0, vd, 1'b1});
      for (int i = 0; i < int'(vc); i++) begin
        logic [15:0] ea;
        ea = va + 16'(i);
        one_transfer(ea, vd);
        cpu_read(2'd0, rd);
        chk("R6 address stepped", {16'd0, rd}, {16'd0, 16'(ea + 16'd1)});
        cpu_read(2'd1, rd);
        chk("R6 count stepped", {16'd0, rd}, {16'd0, 16'(vc - 16'(i) - 16'd1)});
      end
      cpu_read(2'd3, rd);
      chk("R9 done and enable cleared", {16'd0, rd}, 32'h1);
      no_hold_window("R9 dreq ignored after done");
    end

    // R8 / R10: dreq abandoned before grant, write during busy ignored
    cpu_write(2'd0, 16'h0500);
    cpu_write(2'd1, 16'd4);
    cpu_write(2'd2, 16'h0001);
    cpu_read(2'd3, rd);
    chk("R12 done cleared by control write", {16'd0, rd}, 32'h2);
    dreq = 1'b1;
    @(negedge clk);
    chk("R2 hold raised", bus_sig(), 32'h20);
    cpu_read(2'd3, rd);
    chk("R10 busy visible", {16'd0, rd}, 32'h6);
    cpu_write(2'd0, 16'h0777);
    dreq = 1'b0;
    @(negedge clk);
    chk("R8 hold dropped", bus_sig(), 32'h0);
    @(negedge clk);
    cpu_read(2'd0, rd);
    chk("R10 write ignored while busy", {16'd0, rd}, 32'h0500);
    cpu_read(2'd1, rd);
    chk("R8 count unchanged", {16'd0, rd}, 32'd4);

    // R11: enable clear, then count zero
    cpu_write(2'd2, 16'h0000);
    no_hold_window("R11 disabled ignores dreq");
    cpu_write(2'd1, 16'd0);
    cpu_write(2'd2, 16'h0001);
    no_hold_window("R11 zero count ignores dreq");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule